// File: doc/BRIEF.md
# Power-Good Interrupt Aggregator

This block gathers seven fault flags from a multi-rail power supply (a power-fail detector, a low-battery detector, three switching converters and two linear regulators) into one read-only status byte. A writable mask byte and a per-bit block state filter the status byte, and what remains drives a single active-low interrupt line. The line also serves as an all-supplies-OK indicator: it stays high while every enabled supply is in regulation.

Software reads the status byte through a simple register port. A read blocks the faults active at that moment from the interrupt line, so a reported fault does not keep the interrupt asserted. A blocked bit is released as soon as its fault clears, so the next fault on that rail raises the interrupt again.

The block also holds the software enable byte. Each software enable bit is ANDed with its hardware enable pin to give the rail's effective enable. A bit snaps back to 1 while its pin is low. Rails that are off report good in the status byte. The synchronous active-low reset is the undervoltage-lockout event and reloads the mask and enable bytes.

Top module: `pga_top`

## Requirements
- R1: Status byte (read address 0x00) layout: bit 7 power fail, bit 6 low battery, bit 5 converter 1, bit 4 converter 2, bit 3 converter 3, bit 2 LDO2, bit 1 LDO1, bit 0 always 0. A 1 means the fault is active.
- R2: A converter or LDO status bit reads 0 whenever that rail's effective enable is 0, whatever its fault flag.
- R3: The mask byte (address 0x01) is 0xC0 after reset and bits 7..1 are writable. Bit 0 always reads 0. A mask bit of 1 hides the status bit at the same position from the interrupt.
- R4: `irq_n_o` is 0 exactly when some status bit is 1 and neither masked nor blocked. Otherwise it is 1.
- R5: A read of address 0x00 returns the status byte on `reg_rdata` one cycle later. It blocks every status bit that was 1 at that edge from the interrupt, starting the next cycle.
- R6: A blocked bit is unblocked in the cycle after its fault reads 0, so a later fault on that rail drives `irq_n_o` low again.
- R7: The status byte cannot be written. A status read changes neither the mask nor the enable byte.
- R8: The enable byte (address 0x02) holds software enables in bits 5..1, in the same rail order as R1. Bits 7, 6 and 0 read as 1. `rail_on_o[i]` is the enable bit for status bit i+1 ANDed with its pin. Pins: `conv_en_pin[2]`, `[1]` and `[0]` serve converters 1, 2 and 3, and `ldo_en_pin` serves both LDOs.
- R9: While a pin is low, its enable bits read 1 and writes of 0 to them are ignored. When the pin returns high, the rail turns on.
- R10: After reset the enable byte reads 0xFF.
- R11: A read of any address other than 0x00, 0x01 and 0x02 returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (undervoltage lockout) |
| pwr_fail_i | input | 1 | Power-fail detector output, 1 = fault |
| low_bat_i | input | 1 | Low-battery detector output, 1 = fault |
| rail_low_i | input | 5 | Rail below target, 1 = fault; [4] conv1, [3] conv2, [2] conv3, [1] LDO2, [0] LDO1 |
| conv_en_pin | input | 3 | Converter enable pins; [2] conv1, [1] conv2, [0] conv3 |
| ldo_en_pin | input | 1 | Shared LDO enable pin |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the strobe |
| rail_on_o | output | 5 | Effective rail enables, same order as rail_low_i |
| irq_n_o | output | 1 | Active-low interrupt / power-not-OK |

## Verification
A stuck or stale block bit shows up on `irq_n_o` in the same cycle. The symptom is either an interrupt that stays silent when a rail faults again after its fault cleared, or one that stays asserted after software has read the status. A wrong enable bit appears on `rail_on_o` in the cycle after the pin or write that should have set it. It also appears on the next enable read, and through R2 it changes what the status byte reports for that rail. A mask register corrupted by a status read is visible on the next mask read and on the interrupt for any fault it should hide.

// File: rtl/pga_pkg.sv
// Package: shared widths, bit positions, register addresses and reset
// values for the power-good interrupt aggregator.
package pga_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_CONV  = 3;
    localparam int NUM_LDO   = 2;
    localparam int NUM_RAIL  = NUM_CONV + NUM_LDO;
    localparam int RAIL_LSB  = 1;
    localparam int PF_BIT    = 7;
    localparam int LB_BIT    = 6;
    localparam int FLAG_W    = DATA_W - 1;

    typedef logic [DATA_W-1:0] reg_byte_t;

    localparam reg_byte_t MASK_RST  = 8'hC0;
    localparam reg_byte_t EN_RST    = 8'hFF;
    localparam reg_byte_t UNMAPPED  = 8'hFF;
endpackage

// File: rtl/pga_enable.sv
// Module: pga_enable
// Holds the software enable bits, one per rail, and ANDs each with its
// hardware pin. A bit is forced to 1 while its pin is low and on reset.
// Assumes pins are already synchronous to clk.
module pga_enable #(
    parameter int NUM_RAIL = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_RAIL-1:0] pin_i,
    input  logic                wr_i,
    input  logic [NUM_RAIL-1:0] wdata_i,
    output logic [NUM_RAIL-1:0] en_q_o,
    output logic [NUM_RAIL-1:0] on_o
);
    logic [NUM_RAIL-1:0] en_q;

    for (genvar i = 0; i < NUM_RAIL; i++) begin : g_bit
        // Update one software enable bit: reset/pin-low force 1, else write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[i] <= 1'b1;
            else if (!pin_i[i])
                en_q[i] <= 1'b1;
            else if (wr_i)
                en_q[i] <= wdata_i[i];
        end

        // R9: a low pin leaves the bit at 1 on the next cycle
        a_r9_pin_low_forces_one: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_i[i] |=> en_q[i]);

        // R8: a write with the pin high lands in the bit
        a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && pin_i[i]) |=> (en_q[i] == $past(wdata_i[i])));
    end

    assign en_q_o = en_q;
    assign on_o   = en_q & pin_i;

    // R10: all enable bits are 1 in the first cycle after reset
    a_r10_reset_all_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (&en_q));
endmodule

// File: rtl/pga_mask.sv
// Module: pga_mask
// Writable interrupt mask byte. Bit 0 has no source and is held at 0.
// Reset (undervoltage lockout) reloads the configured default.
module pga_mask #(
    parameter int                      DATA_W   = 8,
    parameter logic [DATA_W-1:0]       RST_VAL  = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] mask_o
);
    logic [DATA_W-1:1] mask_q;

    // Load the mask on reset or on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= RST_VAL[DATA_W-1:1];
        else if (wr_i)
            mask_q <= wdata_i[DATA_W-1:1];
    end

    assign mask_o = {mask_q, 1'b0};

    // R3: the reset value is present in the first cycle after reset
    a_r3_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask_o == RST_VAL));

    // R3: without a write the mask holds
    a_r3_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && $past(rst_n)) |=> $stable(mask_o));
endmodule

// File: rtl/pga_status.sv
// Module: pga_status
// Forms the status byte from the fault flags (disabled rails read good),
// keeps the per-bit block state set by status reads and cleared when a
// fault goes away, and drives the active-low combined interrupt.
// Assumes flags are synchronous to clk.
module pga_status
    import pga_pkg::*;
#(
    parameter int NUM_RAIL = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pf_i,
    input  logic                lb_i,
    input  logic [NUM_RAIL-1:0] rail_low_i,
    input  logic [NUM_RAIL-1:0] rail_on_i,
    input  reg_byte_t           mask_i,
    input  logic                rd_status_i,
    output reg_byte_t           status_o,
    output logic                irq_n_o
);
    localparam int BLK_W = DATA_W - 1;

    reg_byte_t          status;
    logic [BLK_W-1:0]   flags;
    logic [BLK_W-1:0]   block_q;
    logic [BLK_W-1:0]   block_d;
    logic [BLK_W-1:0]   live;

    // Assemble the status byte; rails that are off report good.
    always_comb begin
        status                            = '0;
        status[PF_BIT]                    = pf_i;
        status[LB_BIT]                    = lb_i;
        status[RAIL_LSB +: NUM_RAIL]      = rail_low_i & rail_on_i;
    end

    assign flags = status[DATA_W-1:1];

    // Next block state: drop cleared faults, add all faults on a read.
    always_comb begin
        block_d = block_q & flags;
        if (rd_status_i)
            block_d = block_d | flags;
    end

    // Register the block state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            block_q <= '0;
        else
            block_q <= block_d;
    end

    assign live     = flags & ~mask_i[DATA_W-1:1] & ~block_q;
    assign irq_n_o  = ~(|live);
    assign status_o = status;

    for (genvar b = 0; b < BLK_W; b++) begin : g_blk
        // R6: a fault reading 0 releases its block next cycle
        a_r6_clear_unblocks: assert property (@(posedge clk) disable iff (!rst_n)
            !flags[b] |=> !block_q[b]);

        // R5: a status read blocks each fault active at that edge
        a_r5_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_status_i && flags[b]) |=> block_q[b]);
    end

    // R4: an asserted interrupt always has an active unmasked fault
    a_r4_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (|(status & ~mask_i)));

    // R1: bit 0 of the status byte never carries a fault
    a_r1_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[0]);
endmodule

// File: rtl/pga_top.sv
// Module: pga_top
// Power-good interrupt aggregator top: register decode, read data path,
// and the enable, mask and status sub-blocks. Reads return data one
// cycle after the strobe; unmapped reads return all ones.
module pga_top
    import pga_pkg::*;
#(
    parameter int              ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] ADDR_STATUS = 8'h00,
    parameter logic [ADDR_W-1:0] ADDR_MASK   = 8'h01,
    parameter logic [ADDR_W-1:0] ADDR_EN     = 8'h02
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_fail_i,
    input  logic                low_bat_i,
    input  logic [4:0]          rail_low_i,
    input  logic [2:0]          conv_en_pin,
    input  logic                ldo_en_pin,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    output logic [4:0]          rail_on_o,
    output logic                irq_n_o
);
    logic [NUM_RAIL-1:0] pins;
    logic [NUM_RAIL-1:0] en_q;
    logic [NUM_RAIL-1:0] rail_on;
    reg_byte_t           mask;
    reg_byte_t           status;
    reg_byte_t           en_byte;
    reg_byte_t           rdata_q;
    logic                sel_status;
    logic                sel_mask;
    logic                sel_en;

    assign sel_status = (reg_addr == ADDR_STATUS);
    assign sel_mask   = (reg_addr == ADDR_MASK);
    assign sel_en     = (reg_addr == ADDR_EN);

    // Pins in rail order: converters first, then the shared LDO pin twice.
    assign pins = {conv_en_pin, {NUM_LDO{ldo_en_pin}}};

    pga_enable #(.NUM_RAIL(NUM_RAIL)) i_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pins),
        .wr_i    (reg_wr && sel_en),
        .wdata_i (reg_wdata[RAIL_LSB +: NUM_RAIL]),
        .en_q_o  (en_q),
        .on_o    (rail_on)
    );

    pga_mask #(.DATA_W(DATA_W), .RST_VAL(MASK_RST)) i_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr && sel_mask),
        .wdata_i (reg_wdata),
        .mask_o  (mask)
    );

    pga_status #(.NUM_RAIL(NUM_RAIL)) i_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .pf_i        (pwr_fail_i),
        .lb_i        (low_bat_i),
        .rail_low_i  (rail_low_i),
        .rail_on_i   (rail_on),
        .mask_i      (mask),
        .rd_status_i (reg_rd && sel_status),
        .status_o    (status),
        .irq_n_o     (irq_n_o)
    );

    // Enable byte as read: unused bits read 1.
    always_comb begin
        en_byte                          = EN_RST;
        en_byte[RAIL_LSB +: NUM_RAIL]    = en_q;
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (reg_rd) begin
            if (sel_status)      rdata_q <= status;
            else if (sel_mask)   rdata_q <= mask;
            else if (sel_en)     rdata_q <= en_byte;
            else                 rdata_q <= UNMAPPED;
        end
    end

    assign reg_rdata = rdata_q;
    assign rail_on_o = rail_on;

    // R11: unmapped reads return all ones
    a_r11_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !sel_status && !sel_mask && !sel_en) |=> (reg_rdata == UNMAPPED));

    // R7: a status read without a write leaves mask and enables alone
    a_r7_read_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && sel_status && !reg_wr) |=> ($stable(mask) && $stable(en_q)));

    // R2: the status byte never reports a fault on a rail that is off
    a_r2_off_rail_good: assert property (@(posedge clk) disable iff (!rst_n)
        ((status[RAIL_LSB +: NUM_RAIL] & ~rail_on_o) == '0));
endmodule

// File: tb/test_pga_top.sv
`timescale 1ns/1ps
// Bench for pga_top: sweeps fault patterns, masks, pins and enable
// writes, with a bench-side model built from the requirements.
module test_pga_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pf = 1'b0, lb = 1'b0;
    logic [4:0] rl = '0;
    logic [2:0] cpin = 3'b111;
    logic       lpin = 1'b1;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic [7:0] rdata;
    logic [4:0] rail_on;
    logic       irq_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] mask_m, en_m, rd_m;
    logic [7:1] blk_m;

    always #2.5 clk = ~clk;

    pga_top i_pga_top (
        .clk(clk), .rst_n(rst_n), .pwr_fail_i(pf), .low_bat_i(lb),
        .rail_low_i(rl), .conv_en_pin(cpin), .ldo_en_pin(lpin),
        .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .rail_on_o(rail_on), .irq_n_o(irq_n)
    );

    function automatic logic [4:0] pinv();
        return {cpin, lpin, lpin};
    endfunction

    function automatic logic [4:0] on_m();
        return en_m[5:1] & pinv();
    endfunction

    function automatic logic [7:0] st_m();
        return {pf, lb, rl & on_m(), 1'b0};
    endfunction

    function automatic logic irq_m();
        return ~(|(st_m() & ~mask_m & ~{blk_m, 1'b0}));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One clock: update the model from the current bus, then advance.
    task automatic tick();
        logic [7:0] st;
        st = st_m();
        if (!rst_n) begin
            mask_m = 8'hC0; en_m = 8'hFF; blk_m = '0; rd_m = '0;
        end else begin
            if (rd) begin
                case (addr)
                    8'h00:   rd_m = st;
                    8'h01:   rd_m = mask_m;
                    8'h02:   rd_m = en_m;
                    default: rd_m = 8'hFF;
                endcase
            end
            blk_m = (blk_m & st[7:1]) | ((rd && addr == 8'h00) ? st[7:1] : 7'h0);
            if (wr && addr == 8'h01) mask_m = {wdata[7:1], 1'b0};
            for (int i = 1; i <= 5; i++) begin
                if (!pinv()[i-1]) en_m[i] = 1'b1;
                else if (wr && addr == 8'h02) en_m[i] = wdata[i];
            end
        end
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a);
        addr = a; rd = 1'b1; tick();
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1; tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;

        // R10 / R3: reset values; R4 idle interrupt high
        do_read(8'h01); chk(rdata == 8'hC0, "R3 mask reset", rdata, 8'hC0);
        do_read(8'h02); chk(rdata == 8'hFF, "R10 enable reset", rdata, 8'hFF);
        chk(irq_n == 1'b1, "R4 idle irq", {7'b0, irq_n}, 8'h01);

        // R1 R2 R3 R4 R5: sweep pins, masks and all fault patterns
        for (int ps = 0; ps < 4; ps++) begin
            logic [3:0] pp;
            pp = (ps == 0) ? 4'hF : (ps == 1) ? 4'h5 : (ps == 2) ? 4'hA : 4'h0;
            {cpin, lpin} = pp;
            tick();
            for (int ms = 0; ms < 4; ms++) begin
                logic [7:0] mv;
                mv = (ms == 0) ? 8'h00 : (ms == 1) ? 8'hC0 : (ms == 2) ? 8'h7E : 8'hAA;
                do_write(8'h01, mv);
                for (int p = 0; p < 128; p++) begin
                    {pf, lb, rl} = p[6:0];
                    tick();
                    chk(irq_n == irq_m(), "R4 irq after pattern", {7'b0, irq_n}, {7'b0, irq_m()});
                    chk(rail_on == on_m(), "R8 rail_on", {3'b0, rail_on}, {3'b0, on_m()});
                    if (p % 3 == 0) begin
                        do_read(8'h00);
                        chk(rdata == rd_m, "R1 R2 status read", rdata, rd_m);
                        chk(irq_n == irq_m(), "R5 irq after read", {7'b0, irq_n}, {7'b0, irq_m()});
                    end
                end
            end
        end
        {pf, lb, rl} = '0;
        {cpin, lpin} = 4'hF;
        tick();

        // R6: blocked bit releases and a new fault raises the interrupt
        do_write(8'h01, 8'h00);
        rl = 5'b10000; tick();
        chk(irq_n == 1'b0, "R6 fault raises irq", {7'b0, irq_n}, 8'h00);
        do_read(8'h00);
        chk(rdata == 8'h20, "R1 conv1 bit5", rdata, 8'h20);
        chk(irq_n == 1'b1, "R5 read blocks", {7'b0, irq_n}, 8'h01);
        rl = 5'b00001; tick();
        chk(irq_n == 1'b0, "R6 other fault not blocked", {7'b0, irq_n}, 8'h00);
        rl = 5'b00000; tick();
        chk(irq_n == 1'b1, "R6 faults clear", {7'b0, irq_n}, 8'h01);
        rl = 5'b10000; tick();
        chk(irq_n == 1'b0, "R6 re-fault raises irq", {7'b0, irq_n}, 8'h00);
        rl = 5'b00000; tick();

        // R7: status not writable; status read leaves mask and enable alone
        do_write(8'h01, 8'h5A);
        do_write(8'h02, 8'hF5);
        do_write(8'h00, 8'hFF);
        pf = 1'b1; do_read(8'h00);
        chk(rdata == 8'h80, "R7 status not written", rdata, 8'h80);
        pf = 1'b0;
        do_read(8'h01); chk(rdata == 8'h5A, "R7 mask unchanged", rdata, 8'h5A);
        do_read(8'h02); chk(rdata == en_m, "R7 enable unchanged", rdata, en_m);

        // R8 R9: sweep pins against enable writes
        for (int pp = 0; pp < 16; pp++) begin
            for (int w = 0; w < 32; w++) begin
                {cpin, lpin} = pp[3:0];
                tick();
                do_write(8'h02, {2'b00, w[4:0], 1'b0});
                do_read(8'h02);
                chk(rdata == rd_m, "R9 enable readback", rdata, rd_m);
                chk(rail_on == on_m(), "R8 effective enable", {3'b0, rail_on}, {3'b0, on_m()});
            end
        end
        // R9: pin returns high after being low -> rail on
        {cpin, lpin} = 4'hF; do_write(8'h02, 8'h00);
        chk(rail_on == 5'h00, "R8 all off by software", {3'b0, rail_on}, 8'h00);
        cpin = 3'b011; tick(); cpin = 3'b111; tick();
        chk(rail_on == 5'h10, "R9 conv1 back on", {3'b0, rail_on}, 8'h10);

        // R11: every unmapped address reads all ones
        for (int a = 3; a < 256; a++) begin
            do_read(a[7:0]);
            chk(rdata == 8'hFF, "R11 unmapped read", rdata, 8'hFF);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule